// File: doc/BRIEF.md
# GPIO Command Source Arbiter

This block decides which register master may change the pin-state registers of one 32-pin GPIO bank. Three masters share the bank's register port: a primary host, an LPC host and a coprocessor. The bank is cut into four groups of eight pins. Each group has a two-bit owner code. Bit 0 of the code sits in one control register and bit 1 sits in a second control register. In both registers the bit for group g is at position g × 8.

For each write on the shared port, the arbiter produces a per-bit write-enable mask. The bank register file applies this mask, so a write changes only the bits of groups that the writing master owns. The debounce-timer selection registers are open to every master. Reads pass straight through and are never gated.

Owner code 3 is reserved. If a group ever holds code 3, the arbiter locks out every master from that group's pin-state bits and sets a sticky error flag. Moving a group between owners by writing the bit-1 register before the bit-0 register keeps the transitions between the primary host and the coprocessor clear of code 3.

Top module: `gpio_csrc_arb`

## Requirements
- R1: After reset, every owner code is 0 (`owner_o` = 0x00), `err_o` is 0 and `wr_mask_o` is 0.
- R2: A write by the primary host (master ID 0) to byte offset 0x60 loads bit 0 of the owner code of group g from `wr_data_i[8*g]`. A write by the same master to offset 0x64 loads bit 1 from the same position. All other data bits have no effect. The new code appears on `owner_o[2g+1:2g]` after the next rising edge.
- R3: Writes to offsets 0x60 or 0x64 by any master other than ID 0 leave `owner_o` unchanged.
- R4: A write to a pin-state register makes the group's mask bits `wr_mask_o[8g+7:8g]` all ones when the group's owner code equals the master ID (0 primary host, 1 LPC host, 2 coprocessor) and is not 3. Otherwise those mask bits are zero. The pin-state offsets are 0x00, 0x04, 0x08, 0x0C, 0x10, 0x14 and 0x18. The mask is valid in the same cycle as the write.
- R5: A write by any master, including master ID 3, to a debounce-selection register (offsets 0x40 and 0x44) gives an all-ones mask, whatever the owner codes are.
- R6: While a group holds code 3, a pin-state write by any master, including master ID 3, gives zero mask bits for that group. Master ID 3 never receives mask bits for any pin-state write.
- R7: A pin-state write made while at least one group holds code 3 sets `err_o` after the next rising edge. `err_o` then stays at 1 until reset.
- R8: `wr_mask_o` is zero when `wr_en_i` is low, when the address is not a mapped register, and when the address is one of the owner-control registers.
- R9: Moving a group from owner 0 to owner 2 by writing offset 0x64 and then offset 0x60 never shows code 3 on `owner_o`. The same holds for moving from owner 2 to owner 0 in the same order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe on the shared register port |
| wr_master_i | input | 2 | ID of the writing master: 0 primary host, 1 LPC host, 2 coprocessor, 3 reserved |
| wr_addr_i | input | 8 | Byte offset of the write within the bank |
| wr_data_i | input | 32 | Write data |
| owner_o | output | 8 | Owner codes, two bits per group, group g at bits [2g+1:2g] |
| wr_mask_o | output | 32 | Per-bit write enable for the addressed bank register |
| err_o | output | 1 | Sticky flag for a pin-state write made while a reserved code is present |

## Verification
The write mask is combinational from the write port and the stored owner codes, so it is due in the same cycle as the write. Owner codes and the error flag come from registers and change only after the rising edge that captures the write. The bench drives every write at a falling edge and samples the mask 1 ns later, before the capturing edge. It reads `owner_o` and `err_o` at the following falling edge, one full register stage after the write. This lets the check of the sequence that moves a group from owner 0 to owner 2 see each intermediate code exactly once.

// File: rtl/gpio_csrc_pkg.sv
package gpio_csrc_pkg;

  typedef enum logic [1:0] {
    OWN_HOST  = 2'd0,
    OWN_LPC   = 2'd1,
    OWN_COPRO = 2'd2,
    OWN_RSVD  = 2'd3
  } owner_e;

  typedef enum logic [2:0] {
    RC_NONE,
    RC_PIN,
    RC_DEB,
    RC_SRC_LO,
    RC_SRC_HI
  } reg_class_e;

  localparam int unsigned N_PIN_REGS = 7;
  // value, direction, irq enable, irq type x3, irq status
  localparam int unsigned PIN_OFFS [N_PIN_REGS] =
    '{32'h00, 32'h04, 32'h08, 32'h0c, 32'h10, 32'h14, 32'h18};
  localparam int unsigned N_DEB_REGS = 2;
  localparam int unsigned DEB_OFFS [N_DEB_REGS] = '{32'h40, 32'h44};
  localparam int unsigned SRC_LO_OFF = 32'h60;
  localparam int unsigned SRC_HI_OFF = 32'h64;

endpackage

// File: rtl/gpio_csrc_decode.sv
module gpio_csrc_decode
  import gpio_csrc_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input  logic [AW-1:0] addr_i,
  output reg_class_e    cls_o
);

  logic [N_PIN_REGS-1:0] pin_hit;
  logic [N_DEB_REGS-1:0] deb_hit;

  for (genvar i = 0; i < N_PIN_REGS; i++) begin : g_pin
    assign pin_hit[i] = (addr_i == AW'(PIN_OFFS[i]));
  end

  for (genvar i = 0; i < N_DEB_REGS; i++) begin : g_deb
    assign deb_hit[i] = (addr_i == AW'(DEB_OFFS[i]));
  end

  always_comb begin
    cls_o = RC_NONE;
    if (|pin_hit)                        cls_o = RC_PIN;
    else if (|deb_hit)                   cls_o = RC_DEB;
    else if (addr_i == AW'(SRC_LO_OFF))  cls_o = RC_SRC_LO;
    else if (addr_i == AW'(SRC_HI_OFF))  cls_o = RC_SRC_HI;
  end

endmodule

// File: rtl/gpio_csrc_owner.sv
module gpio_csrc_owner #(
  parameter int unsigned NG = 4,
  parameter int unsigned GW = 8,
  localparam int unsigned DW = NG * GW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_lo_i,
  input  logic          we_hi_i,
  input  logic [DW-1:0] data_i,
  output logic [NG-1:0] lo_o,
  output logic [NG-1:0] hi_o
);

  // only bit g*GW of each register is implemented
  for (genvar g = 0; g < NG; g++) begin : g_grp
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lo_o[g] <= 1'b0;
        hi_o[g] <= 1'b0;
      end else begin
        if (we_lo_i) lo_o[g] <= data_i[g*GW];
        if (we_hi_i) hi_o[g] <= data_i[g*GW];
      end
    end
  end

endmodule

// File: rtl/gpio_csrc_gate.sv
module gpio_csrc_gate
  import gpio_csrc_pkg::*;
#(
  parameter int unsigned NG = 4,
  parameter int unsigned GW = 8,
  localparam int unsigned DW = NG * GW
) (
  input  logic          pin_wr_i,
  input  logic          open_wr_i,
  input  logic [1:0]    master_i,
  input  logic [NG-1:0] lo_i,
  input  logic [NG-1:0] hi_i,
  output logic [DW-1:0] mask_o,
  output logic          rsvd_o
);

  logic [NG-1:0] grant;
  logic [NG-1:0] rsvd;

  for (genvar g = 0; g < NG; g++) begin : g_grp
    owner_e code;
    assign code     = owner_e'({hi_i[g], lo_i[g]});
    assign rsvd[g]  = (code == OWN_RSVD);
    assign grant[g] = !rsvd[g] && (code == owner_e'(master_i));
    assign mask_o[g*GW +: GW] = {GW{open_wr_i || (pin_wr_i && grant[g])}};
  end

  assign rsvd_o = |rsvd;

endmodule

// File: rtl/gpio_csrc_arb.sv
module gpio_csrc_arb
  import gpio_csrc_pkg::*;
#(
  parameter int unsigned NG = 4,
  parameter int unsigned GW = 8,
  parameter int unsigned AW = 8,
  localparam int unsigned DW = NG * GW
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic [1:0]      wr_master_i,
  input  logic [AW-1:0]   wr_addr_i,
  input  logic [DW-1:0]   wr_data_i,
  output logic [2*NG-1:0] owner_o,
  output logic [DW-1:0]   wr_mask_o,
  output logic            err_o
);

  reg_class_e    cls;
  logic          host_wr;
  logic          pin_wr;
  logic [NG-1:0] own_lo;
  logic [NG-1:0] own_hi;
  logic          any_rsvd;

  gpio_csrc_decode #(.AW(AW)) i_decode (
    .addr_i (wr_addr_i),
    .cls_o  (cls)
  );

  assign host_wr = wr_en_i && (owner_e'(wr_master_i) == OWN_HOST);
  assign pin_wr  = wr_en_i && (cls == RC_PIN);

  gpio_csrc_owner #(.NG(NG), .GW(GW)) i_owner (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_lo_i (host_wr && (cls == RC_SRC_LO)),
    .we_hi_i (host_wr && (cls == RC_SRC_HI)),
    .data_i  (wr_data_i),
    .lo_o    (own_lo),
    .hi_o    (own_hi)
  );

  gpio_csrc_gate #(.NG(NG), .GW(GW)) i_gate (
    .pin_wr_i  (pin_wr),
    .open_wr_i (wr_en_i && (cls == RC_DEB)),
    .master_i  (wr_master_i),
    .lo_i      (own_lo),
    .hi_i      (own_hi),
    .mask_o    (wr_mask_o),
    .rsvd_o    (any_rsvd)
  );

  for (genvar g = 0; g < NG; g++) begin : g_out
    assign owner_o[2*g +: 2] = {own_hi[g], own_lo[g]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  err_o <= 1'b0;
    else if (pin_wr && any_rsvd)  err_o <= 1'b1;
  end

endmodule

// File: rtl/gpio_csrc_arb_chk.sv
module gpio_csrc_arb_chk #(
  parameter int unsigned NG = 4,
  parameter int unsigned GW = 8,
  parameter int unsigned AW = 8,
  localparam int unsigned DW = NG * GW
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            wr_en_i,
  input logic [1:0]      wr_master_i,
  input logic [AW-1:0]   wr_addr_i,
  input logic [2*NG-1:0] owner_o,
  input logic [DW-1:0]   wr_mask_o,
  input logic            err_o
);

  logic ctrl_a, deb_a, pin_a;
  assign ctrl_a = (wr_addr_i == AW'(8'h60)) || (wr_addr_i == AW'(8'h64));
  assign deb_a  = (wr_addr_i == AW'(8'h40)) || (wr_addr_i == AW'(8'h44));
  assign pin_a  = (wr_addr_i <= AW'(8'h18)) && (wr_addr_i[1:0] == 2'b00);

  a_r8_idle_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i || ctrl_a) |-> (wr_mask_o == '0));

  a_r3_foreign_ctrl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && ctrl_a && wr_master_i != 2'd0) |=> $stable(owner_o));

  a_r5_debounce_open: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && deb_a) |-> (&wr_mask_o));

  a_r7_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);

  for (genvar g = 0; g < NG; g++) begin : g_chk
    a_r6_rsvd_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && pin_a && owner_o[2*g +: 2] == 2'd3) |-> (wr_mask_o[g*GW +: GW] == '0));

    a_r4_owner_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && pin_a && wr_mask_o[g*GW +: GW] != '0) |-> (owner_o[2*g +: 2] == wr_master_i));
  end

endmodule

bind gpio_csrc_arb gpio_csrc_arb_chk #(.NG(NG), .GW(GW), .AW(AW)) i_chk (.*);

// File: tb/test_gpio_csrc_arb.sv
module test_gpio_csrc_arb;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_master_i = '0;
  logic [7:0]  wr_addr_i = '0;
  logic [31:0] wr_data_i = '0;
  logic [7:0]  owner_o;
  logic [31:0] wr_mask_o;
  logic        err_o;

  int checks = 0;
  int failures = 0;
  logic [31:0] m;

  always #2 clk_i = ~clk_i;

  gpio_csrc_arb i_gpio_csrc_arb (.*);

  // {master, addr, expected mask} with owners g0=0 g1=1 g2=2 g3=0
  localparam int NV = 9;
  localparam logic [41:0] VEC [NV] = '{
    {2'd0, 8'h00, 32'hff0000ff},
    {2'd1, 8'h04, 32'h0000ff00},
    {2'd2, 8'h08, 32'h00ff0000},
    {2'd3, 8'h0c, 32'h00000000},
    {2'd0, 8'h18, 32'hff0000ff},
    {2'd2, 8'h40, 32'hffffffff},
    {2'd1, 8'h44, 32'hffffffff},
    {2'd3, 8'h40, 32'hffffffff},
    {2'd1, 8'h30, 32'h00000000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] mst, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_master_i = mst; wr_addr_i = a; wr_data_i = d;
    #1 m = wr_mask_o;
    @(negedge clk_i);
    wr_en_i = 1'b0; wr_data_i = '0;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    failures++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    #7 rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 owner", {24'h0, owner_o}, 32'h0);
    chk("R1 err", {31'h0, err_o}, 32'h0);
    chk("R1/R8 idle mask", wr_mask_o, 32'h0);

    // high register first, then low: g2 -> 2, g1 -> 1
    wr(2'd0, 8'h64, 32'h00010000);
    chk("R8 ctrl mask", m, 32'h0);
    chk("R2 hi write", {24'h0, owner_o}, 32'h20);
    wr(2'd0, 8'h60, 32'h00000100);
    chk("R2 lo write", {24'h0, owner_o}, 32'h24);

    // other data bits have no effect
    wr(2'd0, 8'h64, 32'h7e017e7e);
    chk("R2 spare bits", {24'h0, owner_o}, 32'h24);

    wr(2'd1, 8'h60, 32'hffffffff);
    chk("R3 lpc ctrl", {24'h0, owner_o}, 32'h24);
    wr(2'd2, 8'h64, 32'hffffffff);
    chk("R3 copro ctrl", {24'h0, owner_o}, 32'h24);

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][41:40], VEC[i][39:32], 32'hdeadbeef);
      chk($sformatf("R4/R5/R8 vec%0d", i), m, VEC[i][31:0]);
    end
    chk("R7 no err yet", {31'h0, err_o}, 32'h0);

    // R9: g3 0 -> 2 -> 0, high register first each time
    wr(2'd0, 8'h64, 32'h01010000);
    chk("R9 step hi 0->2", {24'h0, owner_o}, 32'ha4);
    wr(2'd0, 8'h60, 32'h00000100);
    chk("R9 step lo 0->2", {24'h0, owner_o}, 32'ha4);
    wr(2'd0, 8'h64, 32'h00010000);
    chk("R9 step hi 2->0", {24'h0, owner_o}, 32'h24);
    wr(2'd0, 8'h60, 32'h00000100);
    chk("R9 step lo 2->0", {24'h0, owner_o}, 32'h24);

    // force g2 to reserved code 3
    wr(2'd0, 8'h60, 32'h00010100);
    chk("R6 setup", {24'h0, owner_o}, 32'h34);
    chk("R7 err before pin write", {31'h0, err_o}, 32'h0);
    wr(2'd2, 8'h08, 32'hffffffff);
    chk("R6 copro blocked", m, 32'h0);
    chk("R7 err set", {31'h0, err_o}, 32'h1);
    wr(2'd3, 8'h10, 32'hffffffff);
    chk("R6 master3 blocked", m, 32'h0);
    wr(2'd1, 8'h14, 32'h0);
    chk("R6 other groups", m, 32'h0000ff00);
    wr(2'd0, 8'h44, 32'h0);
    chk("R5 debounce with rsvd", m, 32'hffffffff);

    // clear reserved code, flag stays
    wr(2'd0, 8'h60, 32'h00000100);
    chk("R7 owner repaired", {24'h0, owner_o}, 32'h24);
    chk("R7 err sticky", {31'h0, err_o}, 32'h1);
    @(negedge clk_i);
    chk("R8 idle", wr_mask_o, 32'h0);

    rst_ni = 1'b0;
    #1;
    chk("R1 reset owner", {24'h0, owner_o}, 32'h0);
    chk("R1 reset err", {31'h0, err_o}, 32'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    summary();
  end

endmodule